// File: doc/BRIEF.md
# Resettable Discrete Integrator

This block is a sampled-data integrator for fixed-point control loops. A single-cycle strobe marks each sampling instant. On each strobe the running sum moves by a step equal to the sampling period times an input term, and the step is rounded to nearest. The input term depends on a two-bit rule code that can change at run time. It is the trapezoidal average of the present and stored previous inputs, the present input alone (backward rule), or the stored previous input alone (forward rule). The sum saturates at the limits of the signed format instead of wrapping.

An external clear input resets the sum to zero. A mode bit picks how it acts. In edge mode, only the cycle in which the clear input rises has an effect. In level mode, the sum stays at zero for as long as the clear input is high. Each clear also discards the stored previous input. A synchronous global reset loads a caller-supplied initial output value and zeroes the stored input. All data are signed Q16.16 with the default parameters. The sampling period is an input, so one instance can serve several loop rates.

Top module: `discrete_integrator`

## Requirements
- R1: While `rst_n` is low at a clock edge, `y_out` takes the value of `y_init` and the stored previous input becomes zero.
- R2: Rule codes 1 and 3 select the backward rule: on a strobe, `y_out` increases by round(`t_step`·`u_in`), and the new value is visible one clock later.
- R3: Rule code 2 selects the forward rule: on a strobe, `y_out` increases by round(`t_step`·u_prev), where u_prev is the `u_in` captured at the previous strobe.
- R4: Rule code 0 selects the trapezoidal rule: on a strobe, `y_out` increases by round(`t_step`·(`u_in`+u_prev)/2).
- R5: Each step is rounded to the nearest LSB, and an exact half rounds toward positive infinity. So +0.5 LSB becomes 1 and −0.5 LSB becomes 0.
- R6: When the sum leaves the signed 32-bit range, it saturates at 0x7FFFFFFF or 0x80000000.
- R7: In a cycle with no strobe and no clear, neither `y_out` nor u_prev changes.
- R8: When `clr_mode`=0 (edge), `y_out` becomes zero only in the cycle after `clr_ctl` rises. Strobes that arrive while `clr_ctl` stays high accumulate as normal.
- R9: When `clr_mode`=1 (level), `y_out` stays at zero on every cycle in which `clr_ctl` was high, and strobes in those cycles are ignored.
- R10: Any clear also sets u_prev to zero.
- R11: A clear and a strobe in the same cycle give zero, so the clear takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low global reset |
| smp_en | input | 1 | Sampling strobe, one cycle per sample |
| u_in | input | 32 | Signed Q16.16 input sample |
| t_step | input | 32 | Signed Q16.16 sampling period |
| rule_sel | input | 2 | 0 trapezoidal, 1 backward, 2 forward, 3 backward |
| clr_mode | input | 1 | 0 edge clear, 1 level clear |
| clr_ctl | input | 1 | External clear control |
| y_init | input | 32 | Value loaded into the output at global reset |
| y_out | output | 32 | Signed Q16.16 integrator output |

## Verification
The hold and clear properties assume that `y_init` does not change during a reset pulse and that `clr_ctl` is low when reset is released, so that no clear edge coincides with reset release. The monotonic-growth property applies only when both `t_step` and `u_in` are non-negative. The directed stimulus changes inputs only on falling clock edges. It holds `clr_ctl` low between scenarios and changes `y_init` only while reset is asserted.

// File: rtl/integ_pkg.sv
package integ_pkg;
   typedef enum logic [1:0] {
      RULE_TRAP = 2'd0,
      RULE_BWD  = 2'd1,
      RULE_FWD  = 2'd2,
      RULE_ALT  = 2'd3
   } rule_e;
endpackage

// File: rtl/integ_clr_ctrl.sv
module integ_clr_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl,
   input  logic level_mode,
   output logic clr
);
   logic ctl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) ctl_q <= 1'b0;
      else        ctl_q <= ctl;
   end

   assign clr = level_mode ? ctl : (ctl & ~ctl_q);
endmodule

// File: rtl/integ_fxp_scale.sv
module integ_fxp_scale #(
   parameter int DW            = 32,
   parameter int FRAC          = 16,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic signed [DW-1:0] coef,
   input  logic signed [DW:0]   opnd,
   input  logic                 half,
   output logic signed [DW-1:0] res
);
   localparam int PW = 2*DW + 2;
   localparam logic signed [PW-1:0] ONE     = PW'(1);
   localparam logic signed [PW-1:0] BIAS_LO = ONE <<< (FRAC-1);
   localparam logic signed [PW-1:0] BIAS_HI = ONE <<< FRAC;
   localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [PW-1:0] MINV = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

   logic signed [PW-1:0] ce, oe, prod, q_lo, q_hi, q_sel;

   assign ce   = {{(PW-DW){coef[DW-1]}}, coef};
   assign oe   = {{(PW-DW-1){opnd[DW]}}, opnd};
   assign prod = ce * oe;

   generate
      if (ROUND_NEAREST) begin : g_round
         assign q_lo = (prod + BIAS_LO) >>> FRAC;
         assign q_hi = (prod + BIAS_HI) >>> (FRAC+1);
      end else begin : g_trunc
         assign q_lo = prod >>> FRAC;
         assign q_hi = prod >>> (FRAC+1);
      end
   endgenerate

   assign q_sel = half ? q_hi : q_lo;

   always_comb begin
      if (q_sel > MAXV)      res = MAXV[DW-1:0];
      else if (q_sel < MINV) res = MINV[DW-1:0];
      else                   res = q_sel[DW-1:0];
   end
endmodule

// File: rtl/integ_sat_add.sv
module integ_sat_add #(
   parameter int DW = 32
) (
   input  logic signed [DW-1:0] a,
   input  logic signed [DW-1:0] b,
   output logic signed [DW-1:0] sum
);
   logic signed [DW:0] wide;

   assign wide = {a[DW-1], a} + {b[DW-1], b};

   always_comb begin
      if (wide[DW] != wide[DW-1])
         sum = wide[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
      else
         sum = wide[DW-1:0];
   end
endmodule

// File: rtl/discrete_integrator.sv
module discrete_integrator #(
   parameter int DW            = 32,
   parameter int FRAC          = 16,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_en,
   input  logic [DW-1:0] u_in,
   input  logic [DW-1:0] t_step,
   input  logic [1:0]    rule_sel,
   input  logic          clr_mode,
   input  logic          clr_ctl,
   input  logic [DW-1:0] y_init,
   output logic [DW-1:0] y_out
);
   import integ_pkg::*;

   generate
      if (DW < 4)           begin : g_bad_dw   $error("DW too small");        end
      if (FRAC < 1)         begin : g_bad_frac $error("FRAC must be >= 1");   end
      if (FRAC >= DW)       begin : g_bad_fw   $error("FRAC must be < DW");   end
   endgenerate

   logic signed [DW-1:0] y_q, u_prev_q, step, y_next;
   logic signed [DW:0]   u_x, p_x, opnd;
   logic                 half, clr;
   rule_e                rule;

   assign rule = rule_e'(rule_sel);
   assign u_x  = {u_in[DW-1], u_in};
   assign p_x  = {u_prev_q[DW-1], u_prev_q};

   always_comb begin
      half = 1'b0;
      case (rule)
         RULE_TRAP: begin opnd = u_x + p_x; half = 1'b1; end
         RULE_FWD:  opnd = p_x;
         default:   opnd = u_x;
      endcase
   end

   integ_clr_ctrl u_clr (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl        (clr_ctl),
      .level_mode (clr_mode),
      .clr        (clr)
   );

   integ_fxp_scale #(
      .DW            (DW),
      .FRAC          (FRAC),
      .ROUND_NEAREST (ROUND_NEAREST)
   ) u_scale (
      .coef (t_step),
      .opnd (opnd),
      .half (half),
      .res  (step)
   );

   integ_sat_add #(.DW(DW)) u_add (
      .a   (y_q),
      .b   (step),
      .sum (y_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         y_q      <= y_init;
         u_prev_q <= '0;
      end else if (clr) begin
         y_q      <= '0;
         u_prev_q <= '0;
      end else if (smp_en) begin
         y_q      <= y_next;
         u_prev_q <= u_in;
      end
   end

   assign y_out = y_q;
endmodule

// File: rtl/integ_chk.sv
module integ_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          smp_en,
   input logic [DW-1:0] u_in,
   input logic [DW-1:0] t_step,
   input logic [1:0]    rule_sel,
   input logic          clr_mode,
   input logic          clr_ctl,
   input logic [DW-1:0] y_out
);
   logic clr_d;

   always_ff @(posedge clk) begin
      if (!rst_n) clr_d <= 1'b0;
      else        clr_d <= clr_ctl;
   end

   // R9
   level_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mode && clr_ctl) |=> (y_out == '0));

   // R8
   edge_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_mode && clr_ctl && !clr_d) |=> (y_out == '0));

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_en && !clr_ctl) |=> $stable(y_out));

   // R2
   zero_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_en && !clr_ctl && rule_sel == 2'd1 && u_in == '0) |=> $stable(y_out));

   // R6
   monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_en && !clr_ctl && rule_sel == 2'd1 && !t_step[DW-1] && !u_in[DW-1])
      |=> ($signed(y_out) >= $signed($past(y_out))));
endmodule

bind discrete_integrator integ_chk #(.DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .smp_en   (smp_en),
   .u_in     (u_in),
   .t_step   (t_step),
   .rule_sel (rule_sel),
   .clr_mode (clr_mode),
   .clr_ctl  (clr_ctl),
   .y_out    (y_out)
);

// File: tb/sim_discrete_integrator.sv
module sim_discrete_integrator;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_en = 1'b0;
   logic [31:0] u_in = '0;
   logic [31:0] t_step = '0;
   logic [1:0]  rule_sel = 2'd1;
   logic        clr_mode = 1'b0;
   logic        clr_ctl = 1'b0;
   logic [31:0] y_init = '0;
   logic [31:0] y_out;

   int total = 0;
   int fails = 0;
   bit done = 1'b0;

   localparam logic [31:0] ONE  = 32'h0001_0000;
   localparam logic [31:0] HALF = 32'h0000_8000;

   always #2 clk = ~clk;

   discrete_integrator u0 (
      .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .u_in(u_in), .t_step(t_step),
      .rule_sel(rule_sel), .clr_mode(clr_mode), .clr_ctl(clr_ctl),
      .y_init(y_init), .y_out(y_out)
   );

   task automatic chk(input logic [31:0] exp, input string tag);
      total++;
      if (y_out !== exp) begin
         fails++;
         $display("FAIL %s: y_out=%h expected %h", tag, y_out, exp);
      end
   endtask

   task automatic do_reset(input logic [31:0] init);
      @(negedge clk);
      rst_n = 1'b0; y_init = init; clr_ctl = 1'b0; smp_en = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic sample(input logic [1:0] r, input logic [31:0] t, input logic [31:0] u);
      @(negedge clk);
      rule_sel = r; t_step = t; u_in = u; smp_en = 1'b1;
      @(negedge clk);
      smp_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      do_reset(32'h0003_0000);
      chk(32'h0003_0000, "R1 init load");
      sample(2'd2, ONE, ONE);
      chk(32'h0003_0000, "R1 prev input zero after reset");
   endtask

   task automatic t_backward;
      do_reset('0);
      sample(2'd1, HALF, ONE);
      chk(32'h0000_8000, "R2 code1");
      sample(2'd3, HALF, ONE);
      chk(32'h0001_0000, "R2 code3");
   endtask

   task automatic t_forward;
      do_reset('0);
      sample(2'd2, ONE, ONE);
      chk('0, "R3 first uses zero prev");
      sample(2'd2, ONE, 32'h0005_0000);
      chk(32'h0001_0000, "R3 second");
      sample(2'd2, ONE, '0);
      chk(32'h0006_0000, "R3 third");
   endtask

   task automatic t_trap;
      do_reset('0);
      sample(2'd0, ONE, ONE);
      chk(32'h0000_8000, "R4 first");
      sample(2'd0, ONE, 32'h0003_0000);
      chk(32'h0002_8000, "R4 second");
   endtask

   task automatic t_round;
      do_reset('0);
      sample(2'd1, 32'd1, 32'h0000_8000);
      chk(32'd1, "R5 +half up");
      sample(2'd1, 32'd1, 32'h0000_7FFF);
      chk(32'd1, "R5 below half");
      sample(2'd1, 32'd1, 32'hFFFF_8000);
      chk(32'd1, "R5 -half to zero");
      sample(2'd1, 32'd1, 32'hFFFF_7FFF);
      chk(32'd0, "R5 beyond -half");
   endtask

   task automatic t_sat;
      do_reset(32'h7FFF_0000);
      sample(2'd1, ONE, 32'h0002_0000);
      chk(32'h7FFF_FFFF, "R6 positive limit");
      do_reset(32'h8001_0000);
      sample(2'd1, ONE, 32'hFFFE_0000);
      chk(32'h8000_0000, "R6 negative limit");
   endtask

   task automatic t_hold;
      do_reset(ONE);
      @(negedge clk);
      u_in = 32'h0009_0000; t_step = ONE; rule_sel = 2'd1;
      idle(3);
      chk(ONE, "R7 no strobe hold");
      sample(2'd1, ONE, ONE);
      chk(32'h0002_0000, "R7 strobe");
      @(negedge clk);
      u_in = 32'h0007_0000;
      idle(2);
      sample(2'd2, ONE, '0);
      chk(32'h0003_0000, "R7 prev unchanged by idle");
   endtask

   task automatic t_edge;
      do_reset('0);
      clr_mode = 1'b0;
      sample(2'd1, ONE, ONE);
      sample(2'd1, ONE, ONE);
      chk(32'h0002_0000, "R8 before clear");
      @(negedge clk); clr_ctl = 1'b1;
      @(negedge clk);
      chk('0, "R8 rising edge clears");
      sample(2'd1, ONE, ONE);
      chk(ONE, "R8 accumulate while high");
      @(negedge clk); clr_ctl = 1'b0;
      sample(2'd1, ONE, ONE);
      chk(32'h0002_0000, "R8 after release");
   endtask

   task automatic t_level;
      do_reset(32'h0004_0000);
      clr_mode = 1'b1;
      @(negedge clk); clr_ctl = 1'b1;
      sample(2'd1, ONE, ONE);
      chk('0, "R9 held zero 1");
      sample(2'd1, ONE, ONE);
      chk('0, "R9 held zero 2");
      @(negedge clk); clr_ctl = 1'b0;
      sample(2'd1, ONE, ONE);
      chk(ONE, "R9 after release");
      clr_mode = 1'b0;
   endtask

   task automatic t_prev_clear;
      do_reset('0);
      clr_mode = 1'b1;
      sample(2'd2, ONE, 32'h0004_0000);
      @(negedge clk); clr_ctl = 1'b1;
      @(negedge clk); clr_ctl = 1'b0;
      sample(2'd2, ONE, '0);
      chk('0, "R10 prev cleared");
      clr_mode = 1'b0;
   endtask

   task automatic t_prio;
      do_reset('0);
      clr_mode = 1'b0;
      sample(2'd1, ONE, ONE);
      @(negedge clk);
      rule_sel = 2'd1; t_step = ONE; u_in = 32'h0002_0000; smp_en = 1'b1; clr_ctl = 1'b1;
      @(negedge clk);
      smp_en = 1'b0; clr_ctl = 1'b0;
      chk('0, "R11 clear wins");
   endtask

   initial begin
      do_reset('0);
      t_reset();
      t_backward();
      t_forward();
      t_trap();
      t_round();
      t_sat();
      t_hold();
      t_edge();
      t_level();
      t_prev_clear();
      t_prio();
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule